// File: doc/BRIEF.md
# Toggle-Minimizing ALU Control Decoder

This block turns the 4-bit ALU function field of an instruction into five ALU control lines: a pass-through enable, an operand negate, an OR/XOR selector, a logic-result mux selector and a selector between the logic and adder results. Each line is stored in its own set/clear register. Two separate product terms drive that register: a set term and a clear term. A line is written only for the opcodes whose result depends on it. For every other opcode the line keeps its last value, so the datapath behind it sees fewer transitions.

A sequencer-driven instruction enable decides whether the word on the function field is decoded at all. Constants fetched from program memory therefore leave every line untouched. A mode input, `turbo`, switches to a speed-style decode. In that mode every defined opcode writes all five lines with the plain combinational equations, still through the same registers, so latency does not change. The outputs follow the function field one clock after it is sampled with the enable high.

Top module: `alu_ctl_decoder`

## Requirements
- R1: While `rst_n` is low, all five outputs are 0.
- R2: In hold mode (`turbo`=0), `pass_o` becomes 1 for code 1000 (SET) and 0 for codes 0000 (AND) and 0011 (ANDN). It keeps its value for 0001, 0010 and 0100 to 0111.
- R3: `neg_o` becomes 1 for codes 0011, 0100, 0101 and 0110 (ANDN, CMPU, CMPS, SUB). It becomes 0 for 0000, 0001, 0010, 0111 and 1000 (AND, OR, XOR, ADD, SET).
- R4: In hold mode, `orxor_o` becomes 1 only for 0001 (OR) and 0 for 0010 and 0100 to 0111. It keeps its value for 0000, 0011 and 1000.
- R5: In hold mode, `ropmux_o` becomes 1 for 0001 and 0010 and 0 for 0000, 0011 and 1000. It keeps its value for 0100 to 0111.
- R6: `arith_o` becomes 1 for codes 0100 to 0111 and 0 for 0000 to 0011 and 1000.
- R7: A clock edge with `instr_en` low changes no output, whatever the function field holds.
- R8: Codes 1001 to 1111 change no output, in either mode.
- R9: With `turbo`=1, every defined code 0000 to 1000 loads all five outputs with pass=F3, neg=(F1&F0)^F2, orxor=~(F3|F2|F1), ropmux=F1^F0 and arith=F2. Here F3..F0 are the bits of `func`, MSB first.
- R10: A decoded code appears on the outputs right after the rising edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_en | input | 1 | High when the function field carries an instruction |
| turbo | input | 1 | 1 selects full speed-style decode, 0 selects the hold decode |
| func | input | 4 | ALU function field F3..F0 |
| pass_o | output | 1 | Pass-through enable |
| neg_o | output | 1 | Negate second operand |
| orxor_o | output | 1 | OR (1) / XOR (0) selector |
| ropmux_o | output | 1 | Logic-result mux selector |
| arith_o | output | 1 | Adder (1) / logic (0) result selector |

## Verification
The checker relates each output to the function field of the previous cycle through `$past`. It therefore assumes that `func`, `instr_en` and `turbo` are stable and known at every rising edge once reset is released, and that the field carries a defined value during the last reset cycle. The bench meets this by changing inputs only on falling edges and by driving 0000 before releasing reset. Undefined codes and disabled cycles appear only as deliberate stimulus whose expected effect is "no change".

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;

   localparam int CTRL_N = 5;

   // bit positions in the packed control vector {pass, neg, orxor, ropmux, arith}
   localparam int IX_PASS   = 4;
   localparam int IX_NEG    = 3;
   localparam int IX_ORXOR  = 2;
   localparam int IX_ROPMUX = 1;
   localparam int IX_ARITH  = 0;

   typedef enum logic [3:0] {
      FN_AND  = 4'h0,
      FN_OR   = 4'h1,
      FN_XOR  = 4'h2,
      FN_ANDN = 4'h3,
      FN_CMPU = 4'h4,
      FN_CMPS = 4'h5,
      FN_SUB  = 4'h6,
      FN_ADD  = 4'h7,
      FN_SET  = 4'h8
   } alu_fn_e;

   localparam logic [3:0] FN_LAST = 4'h8;

   // speed-style equations, the reference every stored value must agree with
   function automatic logic [CTRL_N-1:0] fast_decode(input logic [3:0] f);
      logic [CTRL_N-1:0] v;
      v[IX_PASS]   = f[3];
      v[IX_NEG]    = (f[1] & f[0]) ^ f[2];
      v[IX_ORXOR]  = ~(f[3] | f[2] | f[1]);
      v[IX_ROPMUX] = f[1] ^ f[0];
      v[IX_ARITH]  = f[2];
      return v;
   endfunction

endpackage

// File: rtl/alu_ctl_terms.sv
module alu_ctl_terms
   import alu_ctl_pkg::*;
#(
   parameter int FUNC_W = 4
)(
   input  logic [FUNC_W-1:0] func,
   input  logic              turbo,
   output logic [CTRL_N-1:0] set_v,
   output logic [CTRL_N-1:0] clr_v
);

   if (FUNC_W != 4) begin : g_bad_width
      $error("alu_ctl_terms: FUNC_W must be 4");
   end

   logic              known;
   logic [CTRL_N-1:0] fast_v;
   logic [CTRL_N-1:0] eco_set;
   logic [CTRL_N-1:0] eco_clr;
   logic [CTRL_N-1:0] trb_set;
   logic [CTRL_N-1:0] trb_clr;
   alu_fn_e           fn;

   assign known  = (func <= FN_LAST);
   assign fn     = alu_fn_e'(func);
   assign fast_v = fast_decode(func);

   // hold-style terms: a line is named only where its value matters
   always_comb begin
      eco_set = '0;
      eco_clr = '0;
      unique case (func)
         FN_AND: begin
            eco_clr[IX_PASS]   = 1'b1;
            eco_clr[IX_NEG]    = 1'b1;
            eco_clr[IX_ROPMUX] = 1'b1;
            eco_clr[IX_ARITH]  = 1'b1;
         end
         FN_OR: begin
            eco_clr[IX_NEG]    = 1'b1;
            eco_set[IX_ORXOR]  = 1'b1;
            eco_set[IX_ROPMUX] = 1'b1;
            eco_clr[IX_ARITH]  = 1'b1;
         end
         FN_XOR: begin
            eco_clr[IX_NEG]    = 1'b1;
            eco_clr[IX_ORXOR]  = 1'b1;
            eco_set[IX_ROPMUX] = 1'b1;
            eco_clr[IX_ARITH]  = 1'b1;
         end
         FN_ANDN: begin
            eco_clr[IX_PASS]   = 1'b1;
            eco_set[IX_NEG]    = 1'b1;
            eco_clr[IX_ROPMUX] = 1'b1;
            eco_clr[IX_ARITH]  = 1'b1;
         end
         FN_CMPU, FN_CMPS, FN_SUB: begin
            eco_set[IX_NEG]    = 1'b1;
            eco_clr[IX_ORXOR]  = 1'b1;
            eco_set[IX_ARITH]  = 1'b1;
         end
         FN_ADD: begin
            eco_clr[IX_NEG]    = 1'b1;
            eco_clr[IX_ORXOR]  = 1'b1;
            eco_set[IX_ARITH]  = 1'b1;
         end
         FN_SET: begin
            eco_set[IX_PASS]   = 1'b1;
            eco_clr[IX_NEG]    = 1'b1;
            eco_clr[IX_ROPMUX] = 1'b1;
            eco_clr[IX_ARITH]  = 1'b1;
         end
         default: ;
      endcase
   end

   // turbo terms: every line written on every defined code
   assign trb_set = {CTRL_N{known}} & fast_v;
   assign trb_clr = {CTRL_N{known}} & ~fast_v;

   assign set_v = turbo ? trb_set : eco_set;
   assign clr_v = turbo ? trb_clr : eco_clr;

   logic unused_fn;
   assign unused_fn = ^fn;

endmodule

// File: rtl/alu_ctl_hold.sv
module alu_ctl_hold #(
   parameter int          N        = 5,
   parameter logic [N-1:0] RST_VAL = '0,
   parameter bit          SET_WINS = 1'b1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [N-1:0] set_v,
   input  logic [N-1:0] clr_v,
   output logic [N-1:0] q
);

   if (N < 1) begin : g_bad_n
      $error("alu_ctl_hold: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_cell
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q[i] <= RST_VAL[i];
            else if (en && set_v[i])   q[i] <= 1'b1;
            else if (en && clr_v[i])   q[i] <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q[i] <= RST_VAL[i];
            else if (en && clr_v[i])   q[i] <= 1'b0;
            else if (en && set_v[i])   q[i] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/alu_ctl_decoder.sv
module alu_ctl_decoder
   import alu_ctl_pkg::*;
#(
   parameter int               FUNC_W   = 4,
   parameter logic [CTRL_N-1:0] RST_VAL = '0,
   parameter bit               SET_WINS = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_en,
   input  logic              turbo,
   input  logic [FUNC_W-1:0] func,
   output logic              pass_o,
   output logic              neg_o,
   output logic              orxor_o,
   output logic              ropmux_o,
   output logic              arith_o
);

   if (FUNC_W != 4) begin : g_bad_width
      $error("alu_ctl_decoder: FUNC_W must be 4");
   end

   logic [CTRL_N-1:0] set_v;
   logic [CTRL_N-1:0] clr_v;
   logic [CTRL_N-1:0] ctl_q;

   alu_ctl_terms #(.FUNC_W(FUNC_W)) u_terms (
      .func  (func),
      .turbo (turbo),
      .set_v (set_v),
      .clr_v (clr_v)
   );

   alu_ctl_hold #(.N(CTRL_N), .RST_VAL(RST_VAL), .SET_WINS(SET_WINS)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (instr_en),
      .set_v (set_v),
      .clr_v (clr_v),
      .q     (ctl_q)
   );

   assign pass_o   = ctl_q[IX_PASS];
   assign neg_o    = ctl_q[IX_NEG];
   assign orxor_o  = ctl_q[IX_ORXOR];
   assign ropmux_o = ctl_q[IX_ROPMUX];
   assign arith_o  = ctl_q[IX_ARITH];

endmodule

// File: rtl/alu_ctl_decoder_chk.sv
module alu_ctl_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       instr_en,
   input logic       turbo,
   input logic [3:0] func,
   input logic       pass_o,
   input logic       neg_o,
   input logic       orxor_o,
   input logic       ropmux_o,
   input logic       arith_o
);

   logic [4:0] q;
   assign q = {pass_o, neg_o, orxor_o, ropmux_o, arith_o};

   function automatic logic [4:0] ref_of(input logic [3:0] f);
      return {f[3], (f[1] & f[0]) ^ f[2], ~(f[3] | f[2] | f[1]), f[1] ^ f[0], f[2]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) AST_RESET_ZERO: assert (q == 5'b0); // R1
   end

   AST_EN_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_en |=> $stable(q)); // R7

   AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      instr_en && (func > 4'd8) |=> $stable(q)); // R8

   AST_TURBO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      instr_en && turbo && (func <= 4'd8) |=> q == ref_of($past(func))); // R9

   AST_PASS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      instr_en && !turbo && (func inside {4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7}) |=> $stable(pass_o)); // R2

   AST_NEG_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      instr_en && (func <= 4'd8) |=> neg_o == ref_of($past(func))[3]); // R3

   AST_ORXOR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      instr_en && !turbo && (func inside {4'd0, 4'd3, 4'd8}) |=> $stable(orxor_o)); // R4

   AST_ROPMUX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      instr_en && !turbo && (func[3:2] == 2'b01) |=> $stable(ropmux_o)); // R5

   AST_ARITH_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      instr_en && (func <= 4'd8) |=> arith_o == ref_of($past(func))[0]); // R6

endmodule

bind alu_ctl_decoder alu_ctl_decoder_chk u_chk (.*);

// File: tb/alu_ctl_decoder_test.sv
`timescale 1ns/1ps
module alu_ctl_decoder_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       instr_en = 1'b0;
   logic       turbo = 1'b0;
   logic [3:0] func = 4'h0;
   logic       pass_o, neg_o, orxor_o, ropmux_o, arith_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   alu_ctl_decoder uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .instr_en (instr_en),
      .turbo    (turbo),
      .func     (func),
      .pass_o   (pass_o),
      .neg_o    (neg_o),
      .orxor_o  (orxor_o),
      .ropmux_o (ropmux_o),
      .arith_o  (arith_o)
   );

   // order of the vector: {pass, neg, orxor, ropmux, arith}
   task automatic chk(input string req, input logic [4:0] exp);
      logic [4:0] act;
      act = {pass_o, neg_o, orxor_o, ropmux_o, arith_o};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   // drive at a falling edge, let one rising edge pass, return at the next falling edge
   task automatic step(input logic [3:0] f, input logic en, input logic tb);
      func = f; instr_en = en; turbo = tb;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 reset", 5'b00000);
   endtask

   task automatic t_hold_sequence();
      step(4'h8, 1, 0); chk("R2 SET sets pass", 5'b10000);
      step(4'h1, 1, 0); chk("R2 R5 OR keeps pass, sets ropmux", 5'b10110);
      step(4'h7, 1, 0); chk("R5 R6 ADD keeps ropmux, sets arith", 5'b10011);
      step(4'h3, 1, 0); chk("R2 R3 ANDN clears pass, sets neg", 5'b01000);
      step(4'h1, 1, 0); chk("R4 OR sets orxor", 5'b00110);
      step(4'h0, 1, 0); chk("R4 AND keeps orxor", 5'b00100);
      step(4'h8, 1, 0); chk("R4 SET keeps orxor", 5'b10100);
      step(4'h5, 1, 0); chk("R3 R6 CMPS", 5'b11001);
      step(4'h2, 1, 0); chk("R4 R5 XOR", 5'b10010);
      step(4'h6, 1, 0); chk("R5 SUB keeps ropmux", 5'b11011);
      step(4'h4, 1, 0); chk("R2 CMPU keeps pass", 5'b11011);
   endtask

   task automatic t_enable_low();
      step(4'h0, 0, 0); chk("R7 AND ignored while disabled", 5'b11011);
      step(4'h1, 0, 1); chk("R7 turbo OR ignored while disabled", 5'b11011);
   endtask

   task automatic t_undefined();
      for (int c = 9; c < 16; c++) begin
         step(c[3:0], 1, c[0]);
         chk("R8 undefined code holds", 5'b11011);
      end
   endtask

   task automatic t_turbo();
      step(4'h0, 1, 1); chk("R9 turbo AND", 5'b00100);
      step(4'h8, 1, 1); chk("R9 turbo SET", 5'b10000);
      step(4'h1, 1, 1); chk("R9 turbo OR", 5'b00110);
      step(4'h7, 1, 1); chk("R9 turbo ADD", 5'b00001);
      step(4'h3, 1, 1); chk("R9 turbo ANDN", 5'b01000);
      step(4'hC, 1, 1); chk("R8 R9 turbo undefined holds", 5'b01000);
   endtask

   task automatic t_latency();
      func = 4'h8; instr_en = 1'b1; turbo = 1'b0;
      @(posedge clk); #1;
      chk("R10 after edge", 5'b10000);
      step(4'h8, 1, 0);
      func = 4'h6;
      #1 chk("R10 before edge", 5'b10000);
      @(negedge clk);
      chk("R10 SUB after edge", 5'b11001);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_hold_sequence();
      t_enable_low();
      t_undefined();
      t_turbo();
      t_latency();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule